// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block sits beside a floating-point datapath. Each operation reports a status vector: the invalid-operation sub-kinds, divide-by-zero, overflow, underflow, rounded, inexact and denormal. The block turns that vector into updates of a floating-point status register, which holds five enable bits, five cause bits, five sticky bits, a flush mode bit and two trap-mode bits, one for single and one for double precision. When the register changes, the block also decides whether the core has to enter the floating-point exception handler. If it does, the block captures the faulting PC and PSW, loads an exception code, and presents the handler vector together with the PSW the core must adopt.

The status input is plain. A status word is accepted in every cycle where `op_valid` is high, so the datapath never sees back-pressure. Software reads the status register through `fpsr_o` and writes all of it through `sw_we`/`sw_wdata`. A software write is the only way to clear sticky bits. Every register changes on the rising clock edge that samples its cause. A synchronous active-high reset clears all registers.

Status vector bit positions are: 0 signalling NaN, 1 inf-inf, 2 inf/inf, 3 0/0, 4 inf*0, 5 convert-to-integer, 6 square root, 7 divide-by-zero, 8 rounded, 9 inexact, 10 overflow, 11 underflow, 12 denormal. Status register layout: enables [4:0], cause [9:5] and sticky [14:10] each use the same order inside their group (bit 0 invalid, 1 zero-divide, 2 overflow, 3 underflow, 4 inexact), flush mode [15], single trap mode [16], double trap mode [17]. PSW bits used: ID 5, EP 6, NP 7, NPV 16, DMP 17, IMP 18.

Top module: `fpx_exc_unit`

## Requirements
- R1: After reset, `fpsr_o`, `trap_o`, `epc_o`, `epsw_o`, `ecode_o`, `trap_pc_o` and `trap_psw_o` are all zero.
- R2: With the inexact enable (bit 4) set, a status with rounded (8), inexact (9) or overflow (10) sets inexact cause (bit 9) and inexact sticky (bit 14).
- R3: With the invalid enable (bit 0) set, any of status bits 0 to 6 sets invalid cause (bit 5) and invalid sticky (bit 10).
- R4: With the zero-divide enable (bit 1) set, divide-by-zero (status 7) sets the invalid cause and sticky bits. Operations never set zero-divide cause (bit 6) or sticky (bit 11).
- R5: With the overflow enable (bit 2) set, overflow (status 10) sets overflow cause (bit 7) and sticky (bit 12).
- R6: Underflow (11) or denormal (12) sets underflow cause (bit 8) and sticky (bit 13) when the underflow enable (bit 3) is set or flush mode (bit 15) is clear. Otherwise it has no effect.
- R7: An operation that raises at least one flag replaces the whole cause field with the new causes and ORs them into the sticky field. An operation that raises none leaves the status register unchanged.
- R8: A flag-raising operation traps when PSW NP and ID are both clear, or when the trap-mode bit for its precision (`op_double` selects bit 17, otherwise bit 16) is clear. No trap happens without a flag.
- R9: One cycle after a trapping operation, `trap_o` pulses for one cycle. `epc_o`/`epsw_o` hold the PC/PSW given with the operation, and `ecode_o` is 0x71 if the precision's trap-mode bit was set, else 0x72. `trap_pc_o` is 0x70 and `trap_psw_o` is the given PSW with EP and ID set. These values hold until the next trap.
- R10: When `prot_en` is high at trap entry, `trap_psw_o` also has NPV, DMP and IMP cleared.
- R11: Sticky bits are cleared only by a software write. A write in the same cycle as an operation takes precedence, and that operation raises no flag and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Status word valid this cycle |
| op_status | input | 13 | Per-operation status vector |
| op_double | input | 1 | Operation is double precision |
| cur_pc | input | 32 | PC of the operation |
| cur_psw | input | 32 | PSW at the operation |
| prot_en | input | 1 | Protection unit enabled |
| sw_we | input | 1 | Software write of the status register |
| sw_wdata | input | 18 | Software write data |
| fpsr_o | output | 18 | Status register |
| trap_o | output | 1 | Trap entry pulse |
| trap_pc_o | output | 32 | Handler PC for the core |
| trap_psw_o | output | 32 | PSW for the core on trap entry |
| epc_o | output | 32 | Saved exception PC |
| epsw_o | output | 32 | Saved exception PSW |
| ecode_o | output | 16 | Exception code |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. This covers the status register after an operation or write, the trap pulse, and the saved PC, PSW, code, vector and handler PSW. The bench drives each input on the falling edge and lets one rising edge pass. It advances its reference state at that edge from the inputs it just drove, and compares all outputs on the following falling edge. Because the reference also holds the trap registers between traps, the single-cycle width of `trap_o` and the hold of the saved values are checked on every step.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int ST_W       = 13;
  localparam int ST_SNAN    = 0;
  localparam int ST_ISI     = 1;
  localparam int ST_IDI     = 2;
  localparam int ST_ZDZ     = 3;
  localparam int ST_IMZ     = 4;
  localparam int ST_CVI     = 5;
  localparam int ST_SQRT    = 6;
  localparam int ST_DIV0    = 7;
  localparam int ST_ROUNDED = 8;
  localparam int ST_INEXACT = 9;
  localparam int ST_OVF     = 10;
  localparam int ST_UNF     = 11;
  localparam int ST_DENORM  = 12;

  localparam int GRP_W = 5;
  localparam int K_INV = 0;
  localparam int K_DZ  = 1;
  localparam int K_OVF = 2;
  localparam int K_UNF = 3;
  localparam int K_INX = 4;

  localparam int FPSR_W   = 18;
  localparam int F_EN_LO  = 0;
  localparam int F_CA_LO  = F_EN_LO + GRP_W;
  localparam int F_ST_LO  = F_CA_LO + GRP_W;
  localparam int F_FLUSH  = F_ST_LO + GRP_W;
  localparam int F_SMODE  = F_FLUSH + 1;
  localparam int F_DMODE  = F_SMODE + 1;

  localparam int PSW_ID  = 5;
  localparam int PSW_EP  = 6;
  localparam int PSW_NP  = 7;
  localparam int PSW_NPV = 16;
  localparam int PSW_DMP = 17;
  localparam int PSW_IMP = 18;

  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [FPSR_W-1:0] fpsr_t;
endpackage

// File: rtl/fpx_flag_gen.sv
module fpx_flag_gen
  import fpx_pkg::*;
(
  input  logic [ST_W-1:0] st,
  input  grp_t            en,
  input  logic            flush,
  output grp_t            cause,
  output logic            hit
);
  logic inv_kind;
  logic unf_kind;

  always_comb begin
    inv_kind = st[ST_SNAN] | st[ST_ISI] | st[ST_IDI] | st[ST_ZDZ] |
               st[ST_IMZ]  | st[ST_CVI] | st[ST_SQRT];
    unf_kind = st[ST_UNF] | st[ST_DENORM];
    cause        = '0;
    cause[K_INX] = en[K_INX] & (st[ST_ROUNDED] | st[ST_INEXACT] | st[ST_OVF]);
    cause[K_INV] = (en[K_INV] & inv_kind) | (en[K_DZ] & st[ST_DIV0]);
    cause[K_OVF] = en[K_OVF] & st[ST_OVF];
    cause[K_UNF] = (en[K_UNF] | ~flush) & unf_kind;
    hit          = |cause;
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sw_we,
  input  fpsr_t sw_wdata,
  input  logic  upd,
  input  grp_t  cause_new,
  output fpsr_t fpsr
);
  fpsr_t fpsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fpsr_q <= '0;
    end else if (sw_we) begin
      fpsr_q <= sw_wdata;
    end else if (upd) begin
      fpsr_q[F_CA_LO +: GRP_W] <= cause_new;
    end
  end

  // sticky bits are kept separately per flag so each one only accumulates
  grp_t sticky_q;
  for (genvar g = 0; g < GRP_W; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)        sticky_q[g] <= 1'b0;
      else if (sw_we) sticky_q[g] <= sw_wdata[F_ST_LO + g];
      else if (upd)   sticky_q[g] <= sticky_q[g] | cause_new[g];
    end
  end

  always_comb begin
    fpsr = fpsr_q;
    fpsr[F_ST_LO +: GRP_W] = sticky_q;
  end
endmodule

// File: rtl/fpx_trap_ctl.sv
module fpx_trap_ctl
  import fpx_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          CODE_W   = 16,
  parameter logic [15:0] CODE_SET = 16'h0071,
  parameter logic [15:0] CODE_CLR = 16'h0072,
  parameter logic [31:0] VEC      = 32'h0000_0070
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              mode_bit,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] cur_psw,
  input  logic              prot_en,
  output logic              trap_o,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] epsw_o,
  output logic [CODE_W-1:0] ecode_o,
  output logic [DATA_W-1:0] tpc_o,
  output logic [DATA_W-1:0] tpsw_o
);
  logic              take;
  logic [DATA_W-1:0] psw_nx;

  always_comb begin
    take   = fire & ((~cur_psw[PSW_NP] & ~cur_psw[PSW_ID]) | ~mode_bit);
    psw_nx = cur_psw;
    psw_nx[PSW_EP] = 1'b1;
    psw_nx[PSW_ID] = 1'b1;
    if (prot_en) begin
      psw_nx[PSW_NPV] = 1'b0;
      psw_nx[PSW_DMP] = 1'b0;
      psw_nx[PSW_IMP] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o  <= 1'b0;
      epc_o   <= '0;
      epsw_o  <= '0;
      ecode_o <= '0;
      tpc_o   <= '0;
      tpsw_o  <= '0;
    end else begin
      trap_o <= take;
      if (take) begin
        epc_o   <= cur_pc;
        epsw_o  <= cur_psw;
        ecode_o <= mode_bit ? CODE_W'(CODE_SET) : CODE_W'(CODE_CLR);
        tpc_o   <= DATA_W'(VEC);
        tpsw_o  <= psw_nx;
      end
    end
  end
endmodule

// File: rtl/fpx_exc_unit.sv
module fpx_exc_unit
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [ST_W-1:0]   op_status,
  input  logic              op_double,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] cur_psw,
  input  logic              prot_en,
  input  logic              sw_we,
  input  logic [FPSR_W-1:0] sw_wdata,
  output logic [FPSR_W-1:0] fpsr_o,
  output logic              trap_o,
  output logic [DATA_W-1:0] trap_pc_o,
  output logic [DATA_W-1:0] trap_psw_o,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] epsw_o,
  output logic [CODE_W-1:0] ecode_o
);
  fpsr_t fpsr;
  grp_t  cause_new;
  logic  hit;
  logic  fire;
  logic  mode_bit;

  fpx_flag_gen u_flags (
    .st    (op_status),
    .en    (fpsr[F_EN_LO +: GRP_W]),
    .flush (fpsr[F_FLUSH]),
    .cause (cause_new),
    .hit   (hit)
  );

  // a software write wins over an operation in the same cycle
  assign fire     = op_valid & hit & ~sw_we;
  assign mode_bit = op_double ? fpsr[F_DMODE] : fpsr[F_SMODE];

  fpx_status_reg u_fpsr (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .upd       (fire),
    .cause_new (cause_new),
    .fpsr      (fpsr)
  );

  fpx_trap_ctl #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_trap (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .mode_bit (mode_bit),
    .cur_pc   (cur_pc),
    .cur_psw  (cur_psw),
    .prot_en  (prot_en),
    .trap_o   (trap_o),
    .epc_o    (epc_o),
    .epsw_o   (epsw_o),
    .ecode_o  (ecode_o),
    .tpc_o    (trap_pc_o),
    .tpsw_o   (trap_psw_o)
  );

  assign fpsr_o = fpsr;
endmodule

// File: rtl/fpx_exc_chk.sv
module fpx_exc_chk
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              prot_en,
  input logic              sw_we,
  input logic [FPSR_W-1:0] fpsr_o,
  input logic              trap_o,
  input logic [DATA_W-1:0] trap_pc_o,
  input logic [DATA_W-1:0] trap_psw_o,
  input logic [CODE_W-1:0] ecode_o
);
  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_we) |-> ((fpsr_o[F_ST_LO +: GRP_W] & $past(fpsr_o[F_ST_LO +: GRP_W]))
                        == $past(fpsr_o[F_ST_LO +: GRP_W])));

  // R4
  dz_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_we) |-> !$rose(fpsr_o[F_CA_LO + K_DZ]));

  // R7
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(op_valid) && !$past(sw_we)) |-> $stable(fpsr_o));

  // R8
  trap_source_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ($past(op_valid) && !$past(sw_we)));

  // R9
  trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ((ecode_o == CODE_W'(16'h71) || ecode_o == CODE_W'(16'h72)) &&
                trap_pc_o == DATA_W'(32'h70) &&
                trap_psw_o[PSW_EP] && trap_psw_o[PSW_ID]));

  // R10
  trap_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_o && $past(prot_en)) |->
      (!trap_psw_o[PSW_NPV] && !trap_psw_o[PSW_DMP] && !trap_psw_o[PSW_IMP]));
endmodule

bind fpx_exc_unit fpx_exc_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .prot_en    (prot_en),
  .sw_we      (sw_we),
  .fpsr_o     (fpsr_o),
  .trap_o     (trap_o),
  .trap_pc_o  (trap_pc_o),
  .trap_psw_o (trap_psw_o),
  .ecode_o    (ecode_o)
);

// File: tb/fpx_exc_unit_tb.sv
module fpx_exc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [12:0] op_status = '0;
  logic        op_double = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_psw = '0;
  logic        prot_en = 1'b0;
  logic        sw_we = 1'b0;
  logic [17:0] sw_wdata = '0;
  logic [17:0] fpsr_o;
  logic        trap_o;
  logic [31:0] trap_pc_o, trap_psw_o, epc_o, epsw_o;
  logic [15:0] ecode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [17:0] m_fpsr = '0;
  logic        m_trap = 1'b0;
  logic [31:0] m_epc = '0, m_epsw = '0, m_tpc = '0, m_tpsw = '0;
  logic [15:0] m_code = '0;

  always #4 clk = ~clk;

  fpx_exc_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_status(op_status),
    .op_double(op_double), .cur_pc(cur_pc), .cur_psw(cur_psw), .prot_en(prot_en),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .fpsr_o(fpsr_o), .trap_o(trap_o),
    .trap_pc_o(trap_pc_o), .trap_psw_o(trap_psw_o), .epc_o(epc_o),
    .epsw_o(epsw_o), .ecode_o(ecode_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_cause(input logic [12:0] s, input logic [17:0] f);
    logic [4:0] c = '0;
    c[4] = f[4] && (s[8] || s[9] || s[10]);
    c[0] = (f[0] && (|s[6:0])) || (f[1] && s[7]);
    c[2] = f[2] && s[10];
    c[3] = (f[3] || !f[15]) && (s[11] || s[12]);
    return c;
  endfunction

  task automatic check_all(input string tag);
    check(tag, "fpsr", {14'd0, fpsr_o}, {14'd0, m_fpsr});
    check(tag, "trap", {31'd0, trap_o}, {31'd0, m_trap});
    check(tag, "epc", epc_o, m_epc);
    check(tag, "epsw", epsw_o, m_epsw);
    check(tag, "ecode", {16'd0, ecode_o}, {16'd0, m_code});
    check(tag, "trap_pc", trap_pc_o, m_tpc);
    check(tag, "trap_psw", trap_psw_o, m_tpsw);
  endtask

  // called on a falling edge; returns on the next falling edge after checking
  task automatic step(input string tag, input logic v, input logic [12:0] s,
                      input logic dbl, input logic [31:0] pc, input logic [31:0] psw,
                      input logic pe, input logic we, input logic [17:0] wd);
    logic [4:0] c;
    logic       mode, take;
    op_valid = v; op_status = s; op_double = dbl; cur_pc = pc; cur_psw = psw;
    prot_en = pe; sw_we = we; sw_wdata = wd;
    c = ref_cause(s, m_fpsr);
    mode = dbl ? m_fpsr[17] : m_fpsr[16];
    take = v && !we && (c != 0) && ((!psw[7] && !psw[5]) || !mode);
    @(posedge clk);
    m_trap = take;
    if (take) begin
      m_epc = pc; m_epsw = psw; m_code = mode ? 16'h71 : 16'h72; m_tpc = 32'h70;
      m_tpsw = psw | 32'h60;
      if (pe) m_tpsw = m_tpsw & ~32'h0007_0000;
    end
    if (we) m_fpsr = wd;
    else if (v && c != 0) begin
      m_fpsr[9:5] = c;
      m_fpsr[14:10] = m_fpsr[14:10] | c;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  localparam logic [31:0] PSW_NP = 32'h80;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");
    // R2: inexact enable only, both trap modes set, NP set -> no trap
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h30010);
    step("R2", 1, 13'h100, 0, 32'h100, PSW_NP, 0, 0, 0);
    step("R2", 1, 13'h400, 1, 32'h104, PSW_NP, 0, 0, 0);
    // R3: invalid enable
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h30001);
    step("R3", 1, 13'h008, 0, 32'h108, PSW_NP, 0, 0, 0);
    step("R3", 1, 13'h040, 0, 32'h10c, PSW_NP, 0, 0, 0);
    step("R3", 1, 13'h100, 0, 32'h110, PSW_NP, 0, 0, 0);
    // R4: zero-divide enable raises invalid pair
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h30002);
    step("R4", 1, 13'h080, 0, 32'h114, PSW_NP, 0, 0, 0);
    // R5: overflow without inexact enable
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h30004);
    step("R5", 1, 13'h400, 0, 32'h118, PSW_NP, 0, 0, 0);
    // R6: flush on, underflow disabled -> no effect; flush off -> pair
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h38000);
    step("R6", 1, 13'h800, 0, 32'h11c, PSW_NP, 0, 0, 0);
    step("R6", 1, 13'h1000, 0, 32'h120, PSW_NP, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h30000);
    step("R6", 1, 13'h1000, 0, 32'h124, PSW_NP, 0, 0, 0);
    // R7: cause replaced, sticky accumulates
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h30005);
    step("R7", 1, 13'h002, 0, 32'h128, PSW_NP, 0, 0, 0);
    step("R7", 1, 13'h400, 0, 32'h12c, PSW_NP, 0, 0, 0);
    step("R7", 1, 13'h200, 0, 32'h130, PSW_NP, 0, 0, 0);
    // R8/R9: trap with NP=ID=0 and mode set -> 0x71
    step("R9", 1, 13'h001, 1, 32'h200, 32'h0007_0000, 0, 0, 0);
    step("R9", 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
    // R8: NP set but single mode clear -> trap 0x72
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h20001);
    step("R8", 1, 13'h001, 0, 32'h204, PSW_NP | 32'h0007_0000, 0, 0, 0);
    // R8: ID set, double mode set -> no trap
    step("R8", 1, 13'h001, 1, 32'h208, 32'h20, 0, 0, 0);
    // R10: protection enabled clears NPV/DMP/IMP
    step("R10", 1, 13'h001, 0, 32'h20c, 32'h0007_0080, 1, 0, 0);
    // R11: simultaneous write wins; then sticky cleared by write
    step("R11", 1, 13'h001, 0, 32'h210, 32'h0, 0, 1, 18'h00001);
    step("R11", 0, 0, 0, 0, 0, 0, 1, 18'h00000);
    step("R11", 1, 13'h001, 0, 32'h214, 32'h0, 0, 0, 0);
    // random traffic
    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      logic we = ($urandom % 12) == 0;
      step("R7", ($urandom % 4) != 0, 13'($urandom & $urandom & $urandom),
           1'($urandom), $urandom, $urandom, 1'($urandom), we, 18'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule